// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This block is the rounding stage that sits between a floating-point datapath and the logic that packs its result. It receives a sign bit, a mantissa whose two lowest bits are the guard bit (bit 1) and the round bit (bit 0), and a separate sticky bit that stands for everything already shifted away below them. It drops the two low bits and decides from a 2-bit mode field whether to add one unit in the last place. The result can carry into a new leading bit, which leaves the mantissa at 2.0. Renormalising that carry is left to the caller. To make that easy, the block reports whether it rounded up, and it also reports whether the result was inexact.

A sample is accepted on a cycle where `in_valid` is high. The result, the rounded-up flag and the inexact flag appear one clock later, together with `out_valid`. Exponent adjustment, exception trapping and packing into a storage format are left to neighbouring logic.

Top module: `mant_round_unit`

## Requirements
- R1: The output mantissa is the input mantissa shifted right by two, zero-extended to MANT_W bits, plus one when an increment is applied. The carry runs through the full width, so a shifted value of all ones becomes 2^(MANT_W-2) and is not corrected.
- R2: When guard (bit 1), round (bit 0) and sticky are all zero, no increment is applied and the inexact flag is clear, in every mode.
- R3: When any of guard, round or sticky is set, the inexact flag is set, in every mode.
- R4: In mode 2'b00 (nearest, ties to even), the block increments only if guard is set and at least one of these is set: round, sticky, or bit 2 of the input (the LSB after the shift).
- R5: In mode 2'b01 (toward zero), the block never increments.
- R6: In mode 2'b10 (toward plus infinity), the block increments only when the result is inexact and the sign is 0.
- R7: In mode 2'b11 (toward minus infinity), the block increments only when the result is inexact and the sign is 1.
- R8: `out_rounded_up` is high exactly when the increment was applied to the output mantissa.
- R9: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. When `in_valid` is low, the output mantissa and both flags hold their previous values.
- R10: While reset is active and after it is released, before any valid input, `out_valid`, `out_mant`, `out_rounded_up` and `out_inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input sample strobe |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_mant | input | MANT_W | Mantissa; bit 1 is the guard bit and bit 0 is the round bit |
| in_sticky | input | 1 | OR of all bits below the round bit |
| in_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_mant | output | MANT_W | Rounded mantissa with guard and round bits removed |
| out_rounded_up | output | 1 | An increment was applied |
| out_inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
All three results and `out_valid` are due at the first clock edge after the one that captured the input. The bench drives each input on a falling edge. It then samples every output on the next falling edge, exactly one rising edge later, and does so before the following input takes effect. The sweep covers every mantissa value of a narrow instance against every sign, sticky value and mode. The hold and reset checks idle `in_valid` and sample one falling edge later, to confirm that nothing moves.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_POS_INF = 2'b10,
    RM_NEG_INF = 2'b11
  } rnd_mode_e;

  localparam int GR_BITS = 2;
endpackage

// File: rtl/rnd_rst_sync.sv
module rnd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic      sign,
  input  logic      guard,
  input  logic      rnd,
  input  logic      sticky,
  input  logic      lsb,
  input  rnd_mode_e mode,
  output logic      inc,
  output logic      inexact
);
  always_comb begin
    inexact = guard | rnd | sticky;
    inc     = 1'b0;
    if (inexact) begin
      unique case (mode)
        RM_NEAREST: inc = guard & (rnd | sticky | lsb);
        RM_ZERO:    inc = 1'b0;
        RM_POS_INF: inc = ~sign;
        RM_NEG_INF: inc = sign;
        default:    inc = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int WIDTH = 26
) (
  input  logic [WIDTH-1:0] a,
  input  logic             inc,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] carry;

  assign carry[0] = inc;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i] = a[i] ^ carry[i];
    if (i < WIDTH - 1) begin : g_carry
      assign carry[i+1] = a[i] & carry[i];
    end
  end
endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
  import rnd_pkg::*;
#(
  parameter int MANT_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic [MANT_W-1:0] out_mant,
  output logic              out_rounded_up,
  output logic              out_inexact
);
  localparam int KEEP_W = MANT_W - GR_BITS;

  logic              rst_s_n;
  logic [MANT_W-1:0] shifted;
  logic [MANT_W-1:0] summed;
  logic              dec_inc;
  logic              dec_inexact;

  logic              valid_d, valid_q;
  logic [MANT_W-1:0] mant_d, mant_q;
  logic              up_d, up_q;
  logic              inex_d, inex_q;

  rnd_rst_sync u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_s_n)
  );

  assign shifted = {{GR_BITS{1'b0}}, in_mant[MANT_W-1:GR_BITS]};

  rnd_decide u_decide (
    .sign    (in_sign),
    .guard   (in_mant[1]),
    .rnd     (in_mant[0]),
    .sticky  (in_sticky),
    .lsb     (in_mant[GR_BITS]),
    .mode    (rnd_mode_e'(in_mode)),
    .inc     (dec_inc),
    .inexact (dec_inexact)
  );

  rnd_incr #(.WIDTH(MANT_W)) u_incr (
    .a   (shifted),
    .inc (dec_inc),
    .sum (summed)
  );

  // next-state
  always_comb begin
    valid_d = in_valid;
    mant_d  = mant_q;
    up_d    = up_q;
    inex_d  = inex_q;
    if (in_valid) begin
      mant_d = summed;
      up_d   = dec_inc;
      inex_d = dec_inexact;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      valid_q <= 1'b0;
      mant_q  <= '0;
      up_q    <= 1'b0;
      inex_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mant_q  <= mant_d;
      up_q    <= up_d;
      inex_q  <= inex_d;
    end
  end

  assign out_valid      = valid_q;
  assign out_mant       = mant_q;
  assign out_rounded_up = up_q;
  assign out_inexact    = inex_q;

  // R1 / R8: value equals shifted input plus the reported increment
  a_r1_value: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> out_mant ==
      ({{GR_BITS{1'b0}}, $past(in_mant[MANT_W-1:GR_BITS])} + MANT_W'(out_rounded_up)));

  a_r2_exact: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && $past(in_mant[1:0]) == 2'b00 && !$past(in_sticky))
      |-> (!out_inexact && !out_rounded_up));

  a_r3_inexact: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && ($past(in_mant[1:0]) != 2'b00 || $past(in_sticky))) |-> out_inexact);

  a_r5_toward_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && $past(in_mode) == 2'b01) |-> !out_rounded_up);

  a_r6_pos_inf_sign: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && $past(in_mode) == 2'b10 && $past(in_sign)) |-> !out_rounded_up);

  a_r7_neg_inf_sign: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && $past(in_mode) == 2'b11 && !$past(in_sign)) |-> !out_rounded_up);

  a_r8_up_needs_inexact: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_rounded_up |-> out_inexact);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> $past(in_valid));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$past(in_valid) |-> ($stable(out_mant) && $stable(out_rounded_up) && $stable(out_inexact)));

  initial begin
    a_r1_width: assert (MANT_W >= 3 && KEEP_W >= 1);
  end
endmodule

// File: tb/test_mant_round_unit.sv
module test_mant_round_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_sign;
  logic [W-1:0] in_mant;
  logic         in_sticky;
  logic [1:0]   in_mode;
  logic         out_valid;
  logic [W-1:0] out_mant;
  logic         out_rounded_up;
  logic         out_inexact;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  mant_round_unit #(.MANT_W(W)) i_mant_round_unit (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_sign        (in_sign),
    .in_mant        (in_mant),
    .in_sticky      (in_sticky),
    .in_mode        (in_mode),
    .out_valid      (out_valid),
    .out_mant       (out_mant),
    .out_rounded_up (out_rounded_up),
    .out_inexact    (out_inexact)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    logic [W-1:0] last_mant;
    logic         last_up;
    logic         last_inex;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sign   = 1'b0;
    in_mant   = '0;
    in_sticky = 1'b0;
    in_mode   = 2'b00;
    repeat (3) @(negedge clk);
    chk("R10 valid in reset", 32'(out_valid), 0);
    chk("R10 mant in reset", 32'(out_mant), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 valid after reset", 32'(out_valid), 0);
    chk("R10 mant after reset", 32'(out_mant), 0);
    chk("R10 flags after reset", 32'({out_rounded_up, out_inexact}), 0);

    last_mant = '0; last_up = 1'b0; last_inex = 1'b0;
    for (int m = 0; m < (1 << W); m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int st = 0; st < 2; st++) begin
          for (int md = 0; md < 4; md++) begin
            logic g, r, lsb, inex, inc;
            logic [W-1:0] exp_m;
            string tag;
            g    = m[1];
            r    = m[0];
            lsb  = m[2];
            inex = g | r | (st != 0);
            case (md)
              0: begin inc = g & (r | (st != 0) | lsb); tag = "R4 nearest"; end
              1: begin inc = 1'b0;                      tag = "R5 toward zero"; end
              2: begin inc = inex & (s == 0);           tag = "R6 plus inf"; end
              default: begin inc = inex & (s == 1);     tag = "R7 minus inf"; end
            endcase
            exp_m = W'(m >> 2) + W'(inc);
            @(negedge clk);
            in_valid  = 1'b1;
            in_mant   = W'(m);
            in_sign   = s[0];
            in_sticky = st[0];
            in_mode   = md[1:0];
            @(negedge clk);
            chk("R9 valid latency", 32'(out_valid), 1);
            chk("R1 mantissa", 32'(out_mant), 32'(exp_m));
            chk({tag, " / R8 rounded-up"}, 32'(out_rounded_up), 32'(inc));
            chk(inex ? "R3 inexact" : "R2 exact", 32'(out_inexact), 32'(inex));
            last_mant = exp_m; last_up = inc; last_inex = inex;
          end
        end
      end
    end

    // R9: idle strobe with changed inputs must not move the outputs
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_mant   = W'(8'h5A ^ (k * 37));
      in_sign   = k[0];
      in_sticky = 1'b1;
      in_mode   = k[1:0];
      @(negedge clk);
      chk("R9 valid low when idle", 32'(out_valid), 0);
      chk("R9 mant holds", 32'(out_mant), 32'(last_mant));
      chk("R9 flags hold", 32'({out_rounded_up, out_inexact}), 32'({last_up, last_inex}));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule